// File: doc/BRIEF.md
# Double-Buffered Register Update Controller

This block holds two banks of 64 programming registers. The first is a write-side buffer bank that a host fills one byte at a time. The second is an active bank that the rest of the chip reads. A host write only ever touches the buffer bank. The buffer contents reach the active bank all at once, and only when an update event commits them. The active bank can be read back by address at any time.

The update strobe has a selectable direction, set by a bit in the active control register. As an output, which is the state after reset, the block times its own updates with a programmable interval counter. Each internal commit is reported on the strobe as a high pulse of fixed length. As an input, a rising edge on the strobe is brought into the clock domain and commits the buffers. Two write sources feed the buffer bank: a parallel port and a port that carries words from an external serial shifter. A mode pin picks which of the two is accepted. An active-high master reset returns both banks to inert default values.

Top module: `dbuf_upd_ctrl`

## Requirements
- R1: While `mrst` is high, and after it falls, both banks hold their defaults: register 0x00 = 0x00, the period registers (0x01 low byte, 0x02 high byte) hold DEF_PERIOD (default 40), and all other registers are 0x00. `upd_oe` is 1 and `upd_out` is 0.
- R2: A host write changes only the buffer bank. `rd_data` keeps the active value until a commit.
- R3: A commit copies all 64 buffer registers into the active bank on a single clock edge.
- R4: Bit 0 of active register 0x00 sets the strobe direction: 0 is output (`upd_oe`=1) and 1 is input (`upd_oe`=0).
- R5: In input mode, a rising edge on `upd_in` commits. The new active values are visible after the third rising clock edge that follows the first edge at which `upd_in` is sampled high, and not after the second. Holding `upd_in` high, or taking it low, commits nothing. In output mode `upd_in` is ignored, and in input mode `upd_out` stays low.
- R6: In output mode with a nonzero period P = {reg 0x02, reg 0x01}, an internal commit occurs every P clock cycles. The first one falls P cycles after reset is released. Each reload uses the period being committed.
- R7: Each internal commit drives `upd_out` high from the next clock edge for exactly PULSE_LEN (8) cycles, when P >= PULSE_LEN.
- R8: A period of 0 in output mode stops internal commits, so `upd_out` stays low.
- R9: With `par_mode`=1 only parallel writes (`p_we`) are taken. With `par_mode`=0 only serial-side writes (`s_we` while `s_cs_n`=0) are taken. A serial-side write with `s_cs_n`=1 is dropped.
- R10: A write in the same cycle as a commit goes into the buffer bank and not into the active bank. It becomes active at the next commit.
- R11: `rd_data` shows the active register at `rd_addr` in the same cycle, combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| mrst | input | 1 | Master reset, active high, asynchronous |
| par_mode | input | 1 | 1 = parallel port writes, 0 = serial-side writes |
| p_we | input | 1 | Parallel write strobe |
| p_addr | input | 6 | Parallel write address |
| p_data | input | 8 | Parallel write data |
| s_cs_n | input | 1 | Serial-side select, active low |
| s_we | input | 1 | Serial-side word-ready strobe from the shifter |
| s_addr | input | 6 | Serial-side write address |
| s_data | input | 8 | Serial-side write data |
| rd_addr | input | 6 | Readback address into the active bank |
| rd_data | output | 8 | Active register at rd_addr |
| upd_in | input | 1 | Strobe pad input (used when direction is input) |
| upd_out | output | 1 | Strobe pad output, update pulse |
| upd_oe | output | 1 | Strobe pad output enable |

## Verification
The commit path is tried with a burst of random parallel writes before the first timed update. It is also tried with writes placed on the exact commit edge, with external edges that are held, released and repeated, and with long runs of random mixed-source writes closed by external commits. The burst shows whether buffering is complete and the copy is all-at-once. The edge-coincident write tells buffer-first ordering apart from write-through. Held and repeated edges tell edge detection apart from level sensing, and the mixed-source runs tell the mode and select gating apart. Interval and pulse measurements under default, reprogrammed and zero periods tell a reload from the committed value apart from a reload from the old active value.

// File: rtl/dbu_pkg.sv
package dbu_pkg;

   // strobe pad direction, as held in the control register bit
   typedef enum logic {
      DIR_OUT = 1'b0,
      DIR_IN  = 1'b1
   } pin_dir_e;

   // write source selected by the mode pin
   typedef enum logic {
      SRC_SERIAL   = 1'b0,
      SRC_PARALLEL = 1'b1
   } wr_src_e;

   // default register placement
   localparam int CTRL_IDX_DEF = 0;
   localparam int PLO_IDX_DEF  = 1;
   localparam int PHI_IDX_DEF  = 2;
   localparam int DIR_BIT_DEF  = 0;

endpackage

// File: rtl/dbu_wr_select.sv
module dbu_wr_select
   import dbu_pkg::*;
#(
   parameter int ADDR_W    = 6,
   parameter int DATA_W    = 8,
   parameter bit SERIAL_EN = 1'b1
) (
   input  logic              par_mode,
   input  logic              p_we,
   input  logic [ADDR_W-1:0] p_addr,
   input  logic [DATA_W-1:0] p_data,
   input  logic              s_cs_n,
   input  logic              s_we,
   input  logic [ADDR_W-1:0] s_addr,
   input  logic [DATA_W-1:0] s_data,
   output logic              wr_en,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [DATA_W-1:0] wr_data
);

   wr_src_e src_s;
   assign src_s = wr_src_e'(par_mode);

   if (SERIAL_EN) begin : g_dual
      always_comb begin
         if (src_s == SRC_PARALLEL) begin
            wr_en   = p_we;
            wr_addr = p_addr;
            wr_data = p_data;
         end else begin
            wr_en   = s_we & ~s_cs_n;
            wr_addr = s_addr;
            wr_data = s_data;
         end
      end
   end else begin : g_par_only
      logic unused_s;
      assign unused_s = ^{src_s, s_cs_n, s_we, s_addr, s_data};
      assign wr_en    = p_we;
      assign wr_addr  = p_addr;
      assign wr_data  = p_data;
   end

endmodule

// File: rtl/dbu_edge_sync.sv
module dbu_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic async_in,
   output logic rise_o
);

   // STAGES synchroniser flops plus one history flop for the edge
   logic [STAGES:0] chain_q;

   for (genvar gi = 0; gi <= STAGES; gi++) begin : g_stage
      if (gi == 0) begin : g_first
         always_ff @(posedge clk or posedge rst) begin
            if (rst) chain_q[gi] <= 1'b0;
            else     chain_q[gi] <= async_in;
         end
      end else begin : g_next
         always_ff @(posedge clk or posedge rst) begin
            if (rst) chain_q[gi] <= 1'b0;
            else     chain_q[gi] <= chain_q[gi-1];
         end
      end
   end

   assign rise_o = chain_q[STAGES-1] & ~chain_q[STAGES];

endmodule

// File: rtl/dbu_reg_bank.sv
module dbu_reg_bank #(
   parameter int ADDR_W     = 6,
   parameter int DATA_W     = 8,
   parameter int DEF_PERIOD = 40,
   parameter int CTRL_IDX   = 0,
   parameter int PLO_IDX    = 1,
   parameter int PHI_IDX    = 2,
   parameter int DIR_BIT    = 0,
   localparam int NUM_REGS  = 1 << ADDR_W,
   localparam int PER_W     = 2 * DATA_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              commit,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   output logic              act_dir,
   output logic [PER_W-1:0]  act_period,
   output logic [PER_W-1:0]  buf_period
);

   logic [DATA_W-1:0] buf_q [NUM_REGS];
   logic [DATA_W-1:0] act_q [NUM_REGS];
   logic [DATA_W-1:0] dflt_s [NUM_REGS];

   function automatic logic [DATA_W-1:0] dflt_word(input int idx);
      logic [PER_W-1:0] per;
      per = PER_W'(DEF_PERIOD);
      if (idx == PLO_IDX) return per[DATA_W-1:0];
      if (idx == PHI_IDX) return per[PER_W-1:DATA_W];
      return '0;
   endfunction

   for (genvar gi = 0; gi < NUM_REGS; gi++) begin : g_dflt
      assign dflt_s[gi] = dflt_word(gi);
   end

   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         for (int i = 0; i < NUM_REGS; i++) begin
            buf_q[i] <= dflt_s[i];
            act_q[i] <= dflt_s[i];
         end
      end else begin
         // copy reads the pre-edge buffer, so a same-edge write waits
         if (commit) begin
            for (int i = 0; i < NUM_REGS; i++) begin
               act_q[i] <= buf_q[i];
            end
         end
         if (wr_en) begin
            buf_q[wr_addr] <= wr_data;
         end
      end
   end

   assign rd_data    = act_q[rd_addr];
   assign act_dir    = act_q[CTRL_IDX][DIR_BIT];
   assign act_period = {act_q[PHI_IDX], act_q[PLO_IDX]};
   assign buf_period = {buf_q[PHI_IDX], buf_q[PLO_IDX]};

endmodule

// File: rtl/dbu_tick_gen.sv
module dbu_tick_gen #(
   parameter int PER_W      = 16,
   parameter int PULSE_LEN  = 8,
   parameter int DEF_PERIOD = 40,
   localparam int PL_W      = $clog2(PULSE_LEN + 1)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             dir_in,
   input  logic [PER_W-1:0] act_period,
   input  logic [PER_W-1:0] buf_period,
   output logic             tick,
   output logic             pulse
);

   localparam logic [PER_W-1:0] ONE      = PER_W'(1);
   localparam logic [PER_W-1:0] RST_CNT  = PER_W'(DEF_PERIOD) - ONE;
   localparam logic [PL_W-1:0]  PL_LOAD  = PL_W'(PULSE_LEN);
   localparam logic [PL_W-1:0]  PL_ONE   = PL_W'(1);

   logic [PER_W-1:0] cnt_q;
   logic [PL_W-1:0]  pl_q;
   logic             run_s;

   assign run_s = ~dir_in & (act_period != '0);
   assign tick  = run_s & (cnt_q == '0);

   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         cnt_q <= RST_CNT;
      end else if (!run_s) begin
         cnt_q <= act_period - ONE;
      end else if (tick) begin
         // reload from the period that this tick makes active
         cnt_q <= buf_period - ONE;
      end else begin
         cnt_q <= cnt_q - ONE;
      end
   end

   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         pl_q <= '0;
      end else if (dir_in) begin
         pl_q <= '0;
      end else if (tick) begin
         pl_q <= PL_LOAD;
      end else if (pl_q != '0) begin
         pl_q <= pl_q - PL_ONE;
      end
   end

   assign pulse = (pl_q != '0) & ~dir_in;

endmodule

// File: rtl/dbuf_upd_ctrl.sv
module dbuf_upd_ctrl
   import dbu_pkg::*;
#(
   parameter int ADDR_W      = 6,
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2,
   parameter int PULSE_LEN   = 8,
   parameter int DEF_PERIOD  = 40,
   parameter int CTRL_IDX    = CTRL_IDX_DEF,
   parameter int PLO_IDX     = PLO_IDX_DEF,
   parameter int PHI_IDX     = PHI_IDX_DEF,
   parameter int DIR_BIT     = DIR_BIT_DEF,
   parameter bit SERIAL_EN   = 1'b1,
   localparam int NUM_REGS   = 1 << ADDR_W,
   localparam int PER_W      = 2 * DATA_W
) (
   input  logic              clk,
   input  logic              mrst,
   input  logic              par_mode,
   input  logic              p_we,
   input  logic [ADDR_W-1:0] p_addr,
   input  logic [DATA_W-1:0] p_data,
   input  logic              s_cs_n,
   input  logic              s_we,
   input  logic [ADDR_W-1:0] s_addr,
   input  logic [DATA_W-1:0] s_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   input  logic              upd_in,
   output logic              upd_out,
   output logic              upd_oe
);

   // elaboration-time parameter checks
   if (ADDR_W < 2) begin : g_bad_aw
      $error("ADDR_W must be at least 2");
   end
   if (DATA_W < 2) begin : g_bad_dw
      $error("DATA_W must be at least 2");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (PULSE_LEN < 1) begin : g_bad_pl
      $error("PULSE_LEN must be at least 1");
   end
   if (DEF_PERIOD < 0 || DEF_PERIOD >= (1 << PER_W)) begin : g_bad_per
      $error("DEF_PERIOD does not fit the period registers");
   end
   if (CTRL_IDX == PLO_IDX || CTRL_IDX == PHI_IDX || PLO_IDX == PHI_IDX) begin : g_bad_idx
      $error("control and period register indices must differ");
   end
   if (CTRL_IDX >= NUM_REGS || PLO_IDX >= NUM_REGS || PHI_IDX >= NUM_REGS) begin : g_bad_rng
      $error("register index outside the address space");
   end
   if (DIR_BIT >= DATA_W) begin : g_bad_bit
      $error("DIR_BIT outside the data width");
   end

   logic              wr_en_s;
   logic [ADDR_W-1:0] wr_addr_s;
   logic [DATA_W-1:0] wr_data_s;
   logic              ext_rise_s;
   logic              tick_s;
   logic              pulse_s;
   logic              commit_s;
   logic              act_dir_s;
   logic [PER_W-1:0]  act_per_s;
   logic [PER_W-1:0]  buf_per_s;
   pin_dir_e          dir_s;

   assign dir_s = pin_dir_e'(act_dir_s);

   dbu_wr_select #(
      .ADDR_W   (ADDR_W),
      .DATA_W   (DATA_W),
      .SERIAL_EN(SERIAL_EN)
   ) u_sel (
      .par_mode(par_mode),
      .p_we    (p_we),
      .p_addr  (p_addr),
      .p_data  (p_data),
      .s_cs_n  (s_cs_n),
      .s_we    (s_we),
      .s_addr  (s_addr),
      .s_data  (s_data),
      .wr_en   (wr_en_s),
      .wr_addr (wr_addr_s),
      .wr_data (wr_data_s)
   );

   dbu_edge_sync #(
      .STAGES(SYNC_STAGES)
   ) u_sync (
      .clk     (clk),
      .rst     (mrst),
      .async_in(upd_in),
      .rise_o  (ext_rise_s)
   );

   dbu_tick_gen #(
      .PER_W     (PER_W),
      .PULSE_LEN (PULSE_LEN),
      .DEF_PERIOD(DEF_PERIOD)
   ) u_tick (
      .clk       (clk),
      .rst       (mrst),
      .dir_in    (dir_s == DIR_IN),
      .act_period(act_per_s),
      .buf_period(buf_per_s),
      .tick      (tick_s),
      .pulse     (pulse_s)
   );

   // external edges count only in input mode; ticks only run in output mode
   assign commit_s = ((dir_s == DIR_IN) & ext_rise_s) | tick_s;

   dbu_reg_bank #(
      .ADDR_W    (ADDR_W),
      .DATA_W    (DATA_W),
      .DEF_PERIOD(DEF_PERIOD),
      .CTRL_IDX  (CTRL_IDX),
      .PLO_IDX   (PLO_IDX),
      .PHI_IDX   (PHI_IDX),
      .DIR_BIT   (DIR_BIT)
   ) u_bank (
      .clk       (clk),
      .rst       (mrst),
      .wr_en     (wr_en_s),
      .wr_addr   (wr_addr_s),
      .wr_data   (wr_data_s),
      .commit    (commit_s),
      .rd_addr   (rd_addr),
      .rd_data   (rd_data),
      .act_dir   (act_dir_s),
      .act_period(act_per_s),
      .buf_period(buf_per_s)
   );

   assign upd_out = pulse_s;
   assign upd_oe  = (dir_s == DIR_OUT);

endmodule

// File: rtl/dbuf_upd_ctrl_chk.sv
module dbuf_upd_ctrl_chk #(
   parameter int ADDR_W    = 6,
   parameter int DATA_W    = 8,
   parameter int PULSE_LEN = 8,
   localparam int HC_W     = $clog2(PULSE_LEN + 2) + 1
) (
   input logic              clk,
   input logic              mrst,
   input logic              upd_out,
   input logic              upd_oe,
   input logic              commit,
   input logic [ADDR_W-1:0] rd_addr,
   input logic [DATA_W-1:0] rd_data
);

   localparam logic [HC_W-1:0] HC_MAX = {HC_W{1'b1}};

   // length of the current high run of the strobe, saturating
   logic [HC_W-1:0] hi_cnt;
   always_ff @(posedge clk or posedge mrst) begin
      if (mrst)                           hi_cnt <= '0;
      else if (!upd_out)                  hi_cnt <= '0;
      else if (hi_cnt != HC_MAX)          hi_cnt <= hi_cnt + HC_W'(1);
   end

   // R1: leaving reset, the strobe is an idle output
   p_reset_idle_r1: assert property (@(posedge clk) disable iff (mrst)
      $fell(mrst) |-> (upd_oe && !upd_out));

   // R2: without a commit, a held readback address keeps its data
   p_hold_active_r2: assert property (@(posedge clk) disable iff (mrst)
      !commit |=> ((rd_addr != $past(rd_addr)) || $stable(rd_data)));

   // R5: input mode never drives a pulse
   p_quiet_input_r5: assert property (@(posedge clk) disable iff (mrst)
      !upd_oe |-> !upd_out);

   // R7: a commit in output mode is followed by the strobe high
   p_commit_pulse_r7: assert property (@(posedge clk) disable iff (mrst)
      (commit && upd_oe) |=> (upd_out || !upd_oe));

   // R7: a pulse that ends in output mode lasted at least PULSE_LEN cycles
   p_pulse_len_r7: assert property (@(posedge clk) disable iff (mrst)
      ($fell(upd_out) && upd_oe) |-> (hi_cnt >= HC_W'(PULSE_LEN)));

endmodule

bind dbuf_upd_ctrl dbuf_upd_ctrl_chk #(
   .ADDR_W   (ADDR_W),
   .DATA_W   (DATA_W),
   .PULSE_LEN(PULSE_LEN)
) u_chk (
   .clk    (clk),
   .mrst   (mrst),
   .upd_out(upd_out),
   .upd_oe (upd_oe),
   .commit (commit_s),
   .rd_addr(rd_addr),
   .rd_data(rd_data)
);

// File: tb/dbuf_upd_ctrl_tb_top.sv
`timescale 1ns/1ps
module dbuf_upd_ctrl_tb_top;

   localparam int AW  = 6;
   localparam int DW  = 8;
   localparam int NR  = 64;
   localparam int DEF = 40;
   localparam int PL  = 8;

   logic          clk = 1'b0;
   logic          mrst = 1'b1;
   logic          par_mode = 1'b1;
   logic          p_we = 1'b0;
   logic [AW-1:0] p_addr = '0;
   logic [DW-1:0] p_data = '0;
   logic          s_cs_n = 1'b1;
   logic          s_we = 1'b0;
   logic [AW-1:0] s_addr = '0;
   logic [DW-1:0] s_data = '0;
   logic [AW-1:0] rd_addr = '0;
   logic [DW-1:0] rd_data;
   logic          upd_in = 1'b0;
   logic          upd_out;
   logic          upd_oe;

   int nchk = 0;
   int nerr = 0;
   bit done = 1'b0;

   logic [DW-1:0] mbuf [NR];
   logic [DW-1:0] mact [NR];

   always #2.5 clk = ~clk;

   dbuf_upd_ctrl dut_i (
      .clk(clk), .mrst(mrst), .par_mode(par_mode),
      .p_we(p_we), .p_addr(p_addr), .p_data(p_data),
      .s_cs_n(s_cs_n), .s_we(s_we), .s_addr(s_addr), .s_data(s_data),
      .rd_addr(rd_addr), .rd_data(rd_data),
      .upd_in(upd_in), .upd_out(upd_out), .upd_oe(upd_oe)
   );

   function automatic logic [DW-1:0] dflt(input int i);
      logic [15:0] p;
      p = 16'(DEF);
      if (i == 1) return p[7:0];
      if (i == 2) return p[15:8];
      return '0;
   endfunction

   task automatic check(input bit ok, input string msg, input longint act, input longint exp);
      nchk++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s: actual %0h expected %0h", msg, act, exp);
      end
   endtask

   task automatic model_reset();
      for (int i = 0; i < NR; i++) begin
         mbuf[i] = dflt(i);
         mact[i] = dflt(i);
      end
   endtask

   task automatic model_commit();
      for (int i = 0; i < NR; i++) mact[i] = mbuf[i];
   endtask

   task automatic cmp_all(input string tag);
      for (int i = 0; i < NR; i++) begin
         rd_addr = AW'(i);
         #0.02;
         check(rd_data == mact[i], $sformatf("%s readback reg %0d", tag, i), rd_data, mact[i]);
      end
   endtask

   // one cycle of stimulus, entered and left at a falling edge
   task automatic cyc(input logic pm, input logic pwe, input logic [AW-1:0] pa, input logic [DW-1:0] pd,
                      input logic swe, input logic scs, input logic [AW-1:0] sa, input logic [DW-1:0] sd);
      par_mode = pm; p_we = pwe; p_addr = pa; p_data = pd;
      s_we = swe; s_cs_n = scs; s_addr = sa; s_data = sd;
      @(negedge clk);
      if (pm && pwe) mbuf[pa] = pd;
      else if (!pm && swe && !scs) mbuf[sa] = sd;
      p_we = 1'b0; s_we = 1'b0; s_cs_n = 1'b1;
   endtask

   task automatic pwr(input int a, input logic [DW-1:0] d);
      cyc(1'b1, 1'b1, AW'(a), d, 1'b0, 1'b1, '0, '0);
   endtask

   task automatic ext_commit(input string tag);
      int probe;
      probe = -1;
      for (int i = 0; i < NR; i++) if (mbuf[i] != mact[i]) probe = i;
      upd_in = 1'b1;
      repeat (2) @(negedge clk);
      if (probe >= 0) begin
         rd_addr = AW'(probe);
         #0.02;
         check(rd_data == mact[probe], $sformatf("R5 no commit two edges after rise, reg %0d", probe),
               rd_data, mact[probe]);
      end
      @(negedge clk);
      model_commit();
      upd_in = 1'b0;
      cmp_all(tag);
      repeat (3) @(negedge clk);
   endtask

   initial begin
      #1000000;
      if (!done) begin
         nerr++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
         $finish;
      end
   end

   initial begin
      int rise_k, w, n, r, hi, a5;
      logic [AW-1:0] ra;
      logic [DW-1:0] rdv, old10;
      r = $urandom(32'd5150);
      model_reset();

      // ---------- R1: reset state ----------
      repeat (3) @(negedge clk);
      check(upd_oe == 1'b1, "R1 upd_oe in reset", upd_oe, 1);
      check(upd_out == 1'b0, "R1 upd_out in reset", upd_out, 0);
      cmp_all("R1");
      mrst = 1'b0;

      // ---------- burst of writes before first timed commit ----------
      rise_k = 0;
      a5 = 3;
      for (int k = 1; k <= 60; k++) begin
         if (k == 1)      begin ra = 6'd1; rdv = 8'd20; end
         else if (k == 2) begin ra = 6'd2; rdv = 8'd0;  end
         else             begin ra = AW'(3 + ($urandom % 61)); rdv = DW'($urandom); end
         if (k == 5) a5 = ra;
         if (k <= 30) begin p_we = 1'b1; p_addr = ra; p_data = rdv; end
         else p_we = 1'b0;
         @(negedge clk);
         if (k <= 30) mbuf[ra] = rdv;
         if (k == 20) begin
            rd_addr = AW'(a5);
            #0.02;
            check(rd_data == mact[a5], "R2 buffered write not yet active", rd_data, mact[a5]);
         end
         if (upd_out) begin rise_k = k; break; end
      end
      p_we = 1'b0;
      check(rise_k == DEF, "R6 first internal commit after DEF_PERIOD cycles", rise_k, DEF);
      model_commit();
      cmp_all("R3");

      // ---------- pulse width and reload ----------
      w = 0;
      while (upd_out && w < 50) begin w++; @(negedge clk); end
      check(w == PL, "R7 pulse width", w, PL);
      n = rise_k + w;
      while (!upd_out && n < 300) begin @(negedge clk); n++; end
      check(n == rise_k + 20, "R6 interval from committed period", n, rise_k + 20);
      model_commit();

      // ---------- same-edge write, switch to input mode ----------
      pwr(1, 8'd0);
      pwr(2, 8'd0);
      pwr(0, 8'd1);
      repeat (16) @(negedge clk);            // now one cycle before the next commit
      model_commit();
      old10 = mbuf[10];
      p_we = 1'b1; p_addr = 6'd10; p_data = ~old10;
      @(negedge clk);
      mbuf[10] = ~old10;
      p_we = 1'b0;
      rd_addr = 6'd10;
      #0.02;
      check(rd_data == mact[10], "R10 same-edge write kept out of active bank", rd_data, mact[10]);
      check(upd_oe == 1'b0, "R4 direction bit 1 selects input", upd_oe, 0);
      check(upd_out == 1'b0, "R5 no pulse in input mode", upd_out, 0);
      cmp_all("R3 commit with direction change");
      ext_commit("R10 held write committed");

      // ---------- R9: write source selection ----------
      cyc(1'b0, 1'b1, 6'd20, ~mbuf[20], 1'b0, 1'b1, 6'd0, 8'd0);
      cyc(1'b0, 1'b0, 6'd0, 8'd0, 1'b1, 1'b1, 6'd21, ~mbuf[21]);
      cyc(1'b0, 1'b0, 6'd0, 8'd0, 1'b1, 1'b0, 6'd22, ~mbuf[22]);
      cyc(1'b1, 1'b0, 6'd0, 8'd0, 1'b1, 1'b0, 6'd23, ~mbuf[23]);
      ext_commit("R9 source gating");

      // ---------- R5: level held or released commits nothing ----------
      pwr(30, ~mbuf[30]);
      upd_in = 1'b1;
      repeat (6) @(negedge clk);
      model_commit();
      rd_addr = 6'd30;
      #0.02;
      check(rd_data == mact[30], "R5 rising edge commits", rd_data, mact[30]);
      pwr(31, ~mbuf[31]);
      repeat (8) @(negedge clk);
      rd_addr = 6'd31;
      #0.02;
      check(rd_data == mact[31], "R5 held high commits nothing more", rd_data, mact[31]);
      upd_in = 1'b0;
      repeat (8) @(negedge clk);
      #0.02;
      check(rd_data == mact[31], "R5 falling edge commits nothing", rd_data, mact[31]);
      ext_commit("R5 second edge");

      // ---------- random mixed traffic ----------
      for (int round = 0; round < 10; round++) begin
         for (int c = 0; c < 20; c++) begin
            logic pm, pwe, swe, scs;
            logic [AW-1:0] pa, sa;
            logic [DW-1:0] pd, sd;
            pm = 1'($urandom); pwe = 1'($urandom); swe = 1'($urandom); scs = 1'($urandom);
            pa = AW'($urandom); sa = AW'($urandom);
            pd = DW'($urandom); sd = DW'($urandom);
            if (pa == 0) pd[0] = 1'b1;
            if (sa == 0) sd[0] = 1'b1;
            cyc(pm, pwe, pa, pd, swe, scs, sa, sd);
            check(upd_out == 1'b0, "R5 strobe low in input mode", upd_out, 0);
         end
         ext_commit("R9 R3 random round");
      end

      // ---------- R8: zero period in output mode ----------
      pwr(0, 8'd0);
      pwr(1, 8'd0);
      pwr(2, 8'd0);
      ext_commit("R4 back to output");
      check(upd_oe == 1'b1, "R4 direction bit 0 selects output", upd_oe, 1);
      hi = 0;
      for (int c = 0; c < 100; c++) begin
         @(negedge clk);
         if (upd_out) hi++;
      end
      check(hi == 0, "R8 zero period gives no pulses", hi, 0);
      pwr(40, ~mbuf[40]);
      upd_in = 1'b1;
      repeat (6) @(negedge clk);
      rd_addr = 6'd40;
      #0.02;
      check(rd_data == mact[40], "R5 upd_in ignored in output mode", rd_data, mact[40]);
      upd_in = 1'b0;

      // ---------- R1: master reset mid-run, buffers also cleared ----------
      pwr(41, 8'hA5);
      mrst = 1'b1;
      @(negedge clk);
      model_reset();
      check(upd_oe == 1'b1, "R1 upd_oe after mid-run reset", upd_oe, 1);
      check(upd_out == 1'b0, "R1 upd_out after mid-run reset", upd_out, 0);
      cmp_all("R1 mid-run reset");
      mrst = 1'b0;
      n = 0;
      while (!upd_out && n < 200) begin @(negedge clk); n++; end
      check(n == DEF, "R6 first commit after mid-run reset", n, DEF);
      cmp_all("R1 buffer defaults committed");
      rd_addr = 6'd1;
      #0.02;
      check(rd_data == 8'(DEF), "R11 readback of period low byte", rd_data, DEF);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
   end

endmodule